// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns a 24-bit processor bus address into four active-low select lines for external devices. Each select owns a control byte and two bound bytes, all written through a small register port. A select set to memory mode matches a span of 64 KB banks, taken from the top eight address bits. A select set to I/O mode matches one 256-byte page of I/O space. The decode is purely combinational from the address, the strobes and the stored configuration.

Hits on the on-chip RAM or flash override every memory-mode select. When several selects match the same cycle, the one with the lowest index wins. The block also presents the wait-state field of the winning select, so a bus sequencer elsewhere can stretch the access. Registers read back through a combinational read port.

Top module: `chip_sel_decoder`

## Requirements
- R1: After reset every control byte and bound byte reads 0, so each select is in memory mode, disabled, with zero wait states, and all four `cs_n` lines are high.
- R2: On a clock edge with `wr_en` high, `wr_data` is stored into the register picked by `wr_idx` (select 0..3) and `wr_reg` (0 = control, 1 = lower bound / I/O page, 2 = upper bound; 3 stores nothing). `rd_data` returns the stored byte picked by `rd_idx` and `rd_reg`.
- R3: Control bit 3 is the enable. A select whose enable is 0 never drives its line low.
- R4: A memory-mode select (control bit 4 = 0) matches while `mem_req` is high and `addr[23:16]` is within lower bound..upper bound, both ends included.
- R5: An I/O-mode select (control bit 4 = 1) matches while `io_req` is high and `addr[15:8]` equals its lower-bound register.
- R6: A memory-mode select ignores `io_req`, and an I/O-mode select ignores `mem_req`. Without its own strobe, a select stays high.
- R7: While `ram_hit` or `flash_hit` is high, no memory-mode select asserts. I/O-mode selects are not affected.
- R8: When several selects match, only the lowest-numbered one drives low.
- R9: `wait_cnt` equals control bits [2:0] of the asserted select, or 0 when no select is asserted.
- R10: At most one of the four `cs_n` lines is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Bus address |
| mem_req | input | 1 | Memory access in progress |
| io_req | input | 1 | I/O access in progress |
| ram_hit | input | 1 | Address claimed by on-chip RAM |
| flash_hit | input | 1 | Address claimed by on-chip flash |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Select index to write |
| wr_reg | input | 2 | Register within select to write |
| wr_data | input | 8 | Write data |
| rd_idx | input | 2 | Select index to read |
| rd_reg | input | 2 | Register within select to read |
| rd_data | output | 8 | Read data |
| cs_n | output | 4 | Active-low chip selects, bit i is select i |
| wait_cnt | output | 3 | Wait states of the asserted select |

## Verification
The bench builds the block with its defaults: four selects, a 24-bit address and a 3-bit wait field. That makes the inclusive bank bounds at 0x00 and 0xFF reachable, as do all eight wait values and every pairing of two overlapping selects. Directed items cover exact range edges, overlap priority, both strobes against both modes, and each internal-hit override. A randomized run then compares every cycle against a shadow model of the registers.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int BYTE_W      = 8;
    localparam int CTRL_EN_BIT = 3;
    localparam int CTRL_IO_BIT = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } cs_cfg_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2,
        REG_NONE = 2'd3
    } cs_reg_e;
endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
    import csd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [1:0]             wr_reg,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [1:0]             rd_reg,
    output logic [BYTE_W-1:0]      rd_data,
    output cs_cfg_t [NUM_CS-1:0]   cfg_o
);
    typedef struct packed {
        cs_cfg_t [NUM_CS-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < NUM_CS)) begin
            case (cs_reg_e'(wr_reg))
                REG_CTRL: st_d.cfg[wr_idx].ctrl = wr_data;
                REG_LO:   st_d.cfg[wr_idx].lo   = wr_data;
                REG_HI:   st_d.cfg[wr_idx].hi   = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_CS) begin
            case (cs_reg_e'(rd_reg))
                REG_CTRL: rd_data = st_q.cfg[rd_idx].ctrl;
                REG_LO:   rd_data = st_q.cfg[rd_idx].lo;
                REG_HI:   rd_data = st_q.cfg[rd_idx].hi;
                default:  rd_data = '0;
            endcase
        end
    end

    assign cfg_o = st_q.cfg;

    // R2: without a write strobe the configuration holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    // R2: a control write lands in the addressed select
    p_write_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == REG_CTRL && int'(wr_idx) < NUM_CS)
        |=> cfg_o[$past(wr_idx)].ctrl == $past(wr_data));
endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int IO_PAGE_LSB = 8,
    localparam int BANK_LSB   = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cs_cfg_t           cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    input  logic              int_hit,
    output logic              hit
);
    logic [BYTE_W-1:0] bank, page;
    logic              en, io_mode, mem_hit, io_hit;

    assign bank    = addr[BANK_LSB +: BYTE_W];
    assign page    = addr[IO_PAGE_LSB +: BYTE_W];
    assign en      = cfg.ctrl[CTRL_EN_BIT];
    assign io_mode = cfg.ctrl[CTRL_IO_BIT];

    always_comb begin
        mem_hit = mem_req && !int_hit && (bank >= cfg.lo) && (bank <= cfg.hi);
        io_hit  = io_req && (page == cfg.lo);
        hit     = en && (io_mode ? io_hit : mem_hit);
    end

    // R3: only an enabled select can match
    p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cfg.ctrl[CTRL_EN_BIT]);

    // R7: internal memories suppress memory-mode matches
    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg.ctrl[CTRL_IO_BIT]) |-> (!int_hit && mem_req));

    // R6: an I/O-mode match needs the I/O strobe
    p_io_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg.ctrl[CTRL_IO_BIT]) |-> io_req);
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int NUM_CS = 4,
    parameter int WAIT_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CS-1:0]              hit,
    input  logic [NUM_CS-1:0][WAIT_W-1:0]  wait_fld,
    output logic [NUM_CS-1:0]              cs_n,
    output logic [WAIT_W-1:0]              wait_cnt
);
    logic [NUM_CS-1:0] grant;

    always_comb begin
        grant    = '0;
        wait_cnt = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                wait_cnt = wait_fld[i];
            end
        end
        cs_n = ~grant;
    end

    // R10: never more than one select low
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R8: no lower-numbered select was matching when one is granted
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> ((((~cs_n) - 1'b1) & hit) == '0));

    // R9: idle bus reports zero wait states
    p_idle_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (wait_cnt == '0));

    // R8: any match yields a low select
    p_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (cs_n != '1));
endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
    import csd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 3,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    input  logic              ram_hit,
    input  logic              flash_hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_reg,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_reg,
    output logic [7:0]        rd_data,
    output logic [NUM_CS-1:0] cs_n,
    output logic [WAIT_W-1:0] wait_cnt
);
    cs_cfg_t [NUM_CS-1:0]             cfg;
    logic    [NUM_CS-1:0]             hit;
    logic    [NUM_CS-1:0][WAIT_W-1:0] wait_fld;
    logic                             int_hit;

    assign int_hit = ram_hit || flash_hit;

    csd_regfile #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_reg(rd_reg), .rd_data(rd_data),
        .cfg_o(cfg)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        csd_match #(.ADDR_W(ADDR_W)) u_match (
            .clk(clk), .rst_n(rst_n), .cfg(cfg[g]), .addr(addr),
            .mem_req(mem_req), .io_req(io_req), .int_hit(int_hit),
            .hit(hit[g])
        );
        assign wait_fld[g] = cfg[g].ctrl[WAIT_W-1:0];
    end

    csd_prio #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wait_fld(wait_fld),
        .cs_n(cs_n), .wait_cnt(wait_cnt)
    );

    // R7: an internal hit with no I/O strobe leaves every line high
    p_int_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_hit && !io_req) |-> (&cs_n));

    // R4: with no strobe at all nothing is selected
    p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !io_req) |-> (&cs_n));
endmodule

// File: tb/test_chip_sel_decoder.sv
module test_chip_sel_decoder;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        mem_req = 1'b0, io_req = 1'b0, ram_hit = 1'b0, flash_hit = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0, wr_reg = '0, rd_idx = '0, rd_reg = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  cs_n;
    logic [2:0]  wait_cnt;

    chip_sel_decoder i_chip_sel_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .io_req(io_req),
        .ram_hit(ram_hit), .flash_hit(flash_hit), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_reg(wr_reg), .wr_data(wr_data), .rd_idx(rd_idx), .rd_reg(rd_reg),
        .rd_data(rd_data), .cs_n(cs_n), .wait_cnt(wait_cnt)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [3:0] cs_n;
        logic [2:0] wt;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0, errors = 0;
    bit    done = 0;

    logic [7:0] sh_ctrl [4];
    logic [7:0] sh_lo   [4];
    logic [7:0] sh_hi   [4];

    // Shadow decode built from R3..R9
    function automatic item_t model(input logic [23:0] a, input logic m, input logic io,
                                    input logic ih, input string tag);
        item_t r;
        r.cs_n = 4'hF; r.wt = 3'd0; r.tag = tag;
        for (int i = 3; i >= 0; i--) begin
            logic match;
            if (sh_ctrl[i][4]) match = io && (a[15:8] == sh_lo[i]);
            else               match = m && !ih && (a[23:16] >= sh_lo[i]) && (a[23:16] <= sh_hi[i]);
            if (sh_ctrl[i][3] && match) begin
                r.cs_n = ~(4'b1 << i);
                r.wt   = sh_ctrl[i][2:0];
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int rg, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_reg = 2'(rg); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (rg == 0) sh_ctrl[idx] = d;
        else if (rg == 1) sh_lo[idx] = d;
        else if (rg == 2) sh_hi[idx] = d;
    endtask

    task automatic rd_check(input int idx, input int rg, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_idx = 2'(idx); rd_reg = 2'(rg);
        #(CLK_P/4);
        check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    // Driver: apply one bus cycle, push the expected result
    task automatic drive(input logic [23:0] a, input logic m, input logic io,
                         input logic rh, input logic fh, input string tag);
        @(negedge clk);
        addr = a; mem_req = m; io_req = io; ram_hit = rh; flash_hit = fh;
        exp_q.push_back(model(a, m, io, rh || fh, tag));
    endtask

    // Explicit expectation, independent of the shadow model
    task automatic drive_x(input logic [23:0] a, input logic m, input logic io,
                           input logic rh, input logic fh, input logic [3:0] ecs,
                           input logic [2:0] ew, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; mem_req = m; io_req = io; ram_hit = rh; flash_hit = fh;
        it.cs_n = ecs; it.wt = ew; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare a quarter period after each driven edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                check(cs_n == e.cs_n, {e.tag, " cs_n"}, 32'(cs_n), 32'(e.cs_n));
                check(wait_cnt == e.wt, {e.tag, " wait_cnt"}, 32'(wait_cnt), 32'(e.wt));
                check($countones(~cs_n) <= 1, {e.tag, " R10 onehot"}, 32'(cs_n), 32'hF);
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            sh_ctrl[i] = '0; sh_lo[i] = '0; sh_hi[i] = '0;
        end
        #(CLK_P * 3);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++)
            for (int r = 0; r < 3; r++)
                rd_check(i, r, 8'h00, "R1 reset reg");
        drive_x(24'h000000, 1, 0, 0, 0, 4'hF, 3'd0, "R1 reset outputs");

        // R2: writes and readback; reg code 3 stores nothing
        wr(0, 0, 8'h0A); wr(0, 1, 8'h10); wr(0, 2, 8'h1F);
        rd_check(0, 0, 8'h0A, "R2 ctrl readback");
        rd_check(0, 1, 8'h10, "R2 lo readback");
        rd_check(0, 2, 8'h1F, "R2 hi readback");
        wr(0, 3, 8'hEE);
        rd_check(0, 0, 8'h0A, "R2 unused code ctrl");
        rd_check(0, 1, 8'h10, "R2 unused code lo");
        rd_check(0, 2, 8'h1F, "R2 unused code hi");

        // R4: inclusive bank range, R9 wait value
        drive_x(24'h100000, 1, 0, 0, 0, 4'b1110, 3'd2, "R4 low edge R9");
        drive_x(24'h1FFFFF, 1, 0, 0, 0, 4'b1110, 3'd2, "R4 high edge");
        drive_x(24'h200000, 1, 0, 0, 0, 4'hF,    3'd0, "R4 above range R9 idle");
        drive_x(24'h0FFFFF, 1, 0, 0, 0, 4'hF,    3'd0, "R4 below range");
        drive_x(24'h150000, 0, 0, 0, 0, 4'hF,    3'd0, "R4 no strobe");
        drive_x(24'h150000, 0, 1, 0, 0, 4'hF,    3'd0, "R6 mem mode ignores io_req");

        // R7: internal overrides
        drive_x(24'h150000, 1, 0, 1, 0, 4'hF, 3'd0, "R7 ram_hit");
        drive_x(24'h150000, 1, 0, 0, 1, 4'hF, 3'd0, "R7 flash_hit");

        // R8: overlapping CS1 range 0x18..0xFF
        wr(1, 1, 8'h18); wr(1, 2, 8'hFF); wr(1, 0, 8'h0D);
        drive_x(24'h180000, 1, 0, 0, 0, 4'b1110, 3'd2, "R8 overlap lowest wins");
        drive_x(24'hFF1234, 1, 0, 0, 0, 4'b1101, 3'd5, "R8 cs1 alone R4 top bank");

        // R5/R6/R7: CS2 in I/O mode, page 0x40, wait 7
        wr(2, 1, 8'h40); wr(2, 0, 8'h1F);
        drive_x(24'h004012, 0, 1, 0, 0, 4'b1011, 3'd7, "R5 io page match");
        drive_x(24'h004112, 0, 1, 0, 0, 4'hF,    3'd0, "R5 io page miss");
        drive_x(24'h004012, 0, 1, 1, 1, 4'b1011, 3'd7, "R7 io unaffected");
        drive_x(24'h004012, 1, 0, 0, 0, 4'hF,    3'd0, "R6 io mode ignores mem_req");

        // R3: CS3 disabled then enabled on bank 0
        wr(3, 1, 8'h00); wr(3, 2, 8'h00); wr(3, 0, 8'h07);
        drive_x(24'h00ABCD, 1, 0, 0, 0, 4'hF,    3'd0, "R3 disabled select");
        wr(3, 0, 8'h0B);
        drive_x(24'h00ABCD, 1, 0, 0, 0, 4'b0111, 3'd3, "R3 enabled select");

        // Randomised sweep against shadow model
        for (int n = 0; n < 300; n++) begin
            if (n % 40 == 0) begin
                int k;
                k = int'($urandom_range(0, 3));
                wr(k, 0, 8'($urandom) & 8'h1F);
                wr(k, 1, 8'($urandom));
                wr(k, 2, 8'($urandom));
            end
            drive(24'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                  "R4 R5 R8 R9 random");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule